// File: doc/BRIEF.md
# Vector Staging Buffer for a Memory-Side Cluster

This unit sits between a vector coprocessor's issue logic and its memory system. Memory latency is hidden by splitting every vector transfer into two separately issued commands around a small pool of local staging registers. A load becomes a fill, in which memory streams into a staging register, followed later by a move-out, in which that register streams to another cluster or to the global register file. A store becomes a move-in, in which data streams into a staging register, followed by a write of that register to memory. Every signal that depends on the memory system is confined to this unit.

Software claims a staging register with an allocate command and returns it with a free command. A variant of the store releases its register by itself once the last element has been written. Addresses are unit-stride word addresses. Memory answers reads in order, with a latency that can vary, and a counter kept for each register tracks how far its fill has progressed. The fill engine returns to idle as soon as its requests have been issued, so other commands can run while read data is still arriving.

Top module: `vstage_top`

## Requirements
- R1: An accepted ALLOC command (op code 0) grants the lowest-numbered free staging register. In the cycle after acceptance, `alloc_valid` is high for one cycle and `alloc_idx` shows the granted index. That register is busy from then on.
- R2: While every staging register is busy, an ALLOC command is held with `cmd_ready` low for as long as it is presented.
- R3: A FILL command (op 1) issues `cmd_len` read requests (`mem_req_we` low) to addresses `cmd_addr`, `cmd_addr+1`, and so on. The in-order responses land in elements 0 to `cmd_len-1` of the target register.
- R4: A MOVE_OUT command (op 2) is held with `cmd_ready` low until every element of its register's fill has returned.
- R5: A move-out presents the elements in index order on `mo_data` and advances only when `mo_valid` and `mo_ready` are both high. `mo_last` is high on the final element, and data stays stable while it is stalled.
- R6: A MOVE_IN command (op 3) takes `cmd_len` words through `mi_valid`/`mi_ready` into elements 0 upward, and sets the register's length to `cmd_len`.
- R7: A STORE command (op 4) writes the register's elements to `cmd_addr+i` with `mem_req_we` high. Afterwards the register stays allocated.
- R8: A STORE_FREE command (op 5) performs the same writes as R7 and then returns the register to the free pool, with no separate free command needed.
- R9: A FREE command (op 6) returns its register to the free pool immediately.
- R10: A memory request that is stalled by `mem_req_ready` low keeps its valid, address, direction and write data unchanged.
- R11: A FILL command is held with `cmd_ready` low while responses for an earlier fill are still outstanding.
- R12: After reset no register is busy, no memory request, move-out or allocation result is presented, and the unit is ready for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 3 | Operation code (0 ALLOC … 6 FREE) |
| cmd_reg | input | RW | Target staging register |
| cmd_addr | input | AW | Word base address for FILL and STORE |
| cmd_len | input | LW | Element count for FILL and MOVE_IN (1 to DEPTH) |
| alloc_valid | output | 1 | One-cycle allocation result strobe |
| alloc_idx | output | RW | Granted staging register |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | High for write, low for read |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data returned (in order) |
| mem_rsp_data | input | DW | Read data |
| mo_valid | output | 1 | Move-out element present |
| mo_ready | input | 1 | Receiver takes move-out element |
| mo_data | output | DW | Move-out element |
| mo_last | output | 1 | Final element of the move-out |
| mi_valid | input | 1 | Move-in element present |
| mi_ready | output | 1 | Unit takes move-in element |
| mi_data | input | DW | Move-in element |

## Verification
Several properties are checked on every cycle: a move-out only runs on a fully filled register, and a stalled memory request or move-out keeps its values unchanged. The checks also cover that no read response arrives without an outstanding fill, that no register is granted twice, that fill counters never pass the register length, and that the two element writers never target the same register. Other behaviour needs directed scenarios. These cover the allocation order and the stall when the pool is full, the data values after fill, move-in and store, and the stall cycles counted before a move-out or a second fill. They also show at the ports, through the next allocation result, whether a plain store left its register allocated and whether a store-and-free or a free released its register.

// File: rtl/vstage_pkg.sv
package vstage_pkg;

   typedef enum logic [2:0] {
      OP_ALLOC   = 3'd0,
      OP_FILL    = 3'd1,
      OP_MOUT    = 3'd2,
      OP_MIN     = 3'd3,
      OP_STORE   = 3'd4,
      OP_STFREE  = 3'd5,
      OP_FREE    = 3'd6
   } stage_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_MOUT,
      ST_MIN,
      ST_STORE
   } stage_state_e;

endpackage

// File: rtl/vstage_alloc.sv
module vstage_alloc #(
   parameter int NREG = 8,
   localparam int RW = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [RW-1:0] set_idx,
   input  logic          clr_en,
   input  logic [RW-1:0] clr_idx,
   output logic [RW-1:0] free_idx,
   output logic          all_busy
);

   logic [NREG-1:0] busy_q;

   for (genvar g = 0; g < NREG; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            busy_q[g] <= 1'b0;
         else if (set_en && set_idx == RW'(g))
            busy_q[g] <= 1'b1;
         else if (clr_en && clr_idx == RW'(g))
            busy_q[g] <= 1'b0;
      end
   end

   always_comb begin
      free_idx = '0;
      for (int i = NREG - 1; i >= 0; i--)
         if (!busy_q[i]) free_idx = RW'(i);
   end

   assign all_busy = &busy_q;

   // R1
   no_double_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !busy_q[set_idx]);

endmodule

// File: rtl/vstage_track.sv
module vstage_track #(
   parameter int NREG  = 8,
   parameter int DEPTH = 8,
   localparam int RW = $clog2(NREG),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_en,
   input  logic [RW-1:0]            set_reg,
   input  logic [LW-1:0]            set_len,
   input  logic                     inc_a_en,
   input  logic [RW-1:0]            inc_a_reg,
   input  logic                     inc_b_en,
   input  logic [RW-1:0]            inc_b_reg,
   output logic [NREG-1:0][LW-1:0]  len_o,
   output logic [NREG-1:0][LW-1:0]  cnt_o,
   output logic [NREG-1:0]          done_o
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [LW-1:0] len_q, cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            len_q <= '0;
            cnt_q <= '0;
         end else if (set_en && set_reg == RW'(g)) begin
            len_q <= set_len;
            cnt_q <= '0;
         end else if (inc_a_en && inc_a_reg == RW'(g)) begin
            cnt_q <= cnt_q + LW'(1);
         end else if (inc_b_en && inc_b_reg == RW'(g)) begin
            cnt_q <= cnt_q + LW'(1);
         end
      end

      assign len_o[g]  = len_q;
      assign cnt_o[g]  = cnt_q;
      assign done_o[g] = (len_q != '0) && (cnt_q == len_q);

      // R3
      fill_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= len_q);
   end

endmodule

// File: rtl/vstage_regfile.sv
module vstage_regfile #(
   parameter int NREG  = 8,
   parameter int DEPTH = 8,
   parameter int DW    = 32,
   localparam int RW = $clog2(NREG),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wa_en,
   input  logic [RW-1:0] wa_reg,
   input  logic [LW-1:0] wa_idx,
   input  logic [DW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [RW-1:0] wb_reg,
   input  logic [LW-1:0] wb_idx,
   input  logic [DW-1:0] wb_data,
   input  logic [RW-1:0] rd_reg,
   input  logic [LW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] elem_q [NREG][DEPTH];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      for (genvar e = 0; e < DEPTH; e++) begin : g_elem
         always_ff @(posedge clk) begin
            if (wa_en && wa_reg == RW'(r) && wa_idx == LW'(e))
               elem_q[r][e] <= wa_data;
            else if (wb_en && wb_reg == RW'(r) && wb_idx == LW'(e))
               elem_q[r][e] <= wb_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < NREG; r++)
         for (int e = 0; e < DEPTH; e++)
            if (rd_reg == RW'(r) && rd_idx == LW'(e)) rd_data = elem_q[r][e];
   end

   // R6
   no_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wa_en && wb_en |-> wa_reg != wb_reg);

endmodule

// File: rtl/vstage_top.sv
module vstage_top
   import vstage_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int DEPTH = 8,
   parameter int DW    = 32,
   parameter int AW    = 16,
   localparam int RW = $clog2(NREG),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [2:0]    cmd_op,
   input  logic [RW-1:0] cmd_reg,
   input  logic [AW-1:0] cmd_addr,
   input  logic [LW-1:0] cmd_len,
   output logic          alloc_valid,
   output logic [RW-1:0] alloc_idx,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic          mem_req_we,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          mo_valid,
   input  logic          mo_ready,
   output logic [DW-1:0] mo_data,
   output logic          mo_last,
   input  logic          mi_valid,
   output logic          mi_ready,
   input  logic [DW-1:0] mi_data
);

   if (NREG < 4 || NREG > 8) begin : g_bad_nreg
      $error("vstage_top: NREG must lie in 4..8");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("vstage_top: DEPTH must be at least 2");
   end

   stage_state_e  state_q;
   stage_op_e     op;
   logic          acc;
   logic [LW-1:0] idx_q, idx_nxt, len_cur_q;
   logic [RW-1:0] cur_reg_q, fill_reg_q, alloc_idx_q, free_idx;
   logic [AW-1:0] base_q;
   logic          free_after_q, fill_act_q, alloc_valid_q, all_busy, fill_pend;
   logic          is_last, clr_en;
   logic [RW-1:0] clr_idx;
   logic [NREG-1:0][LW-1:0] len_o, cnt_o;
   logic [NREG-1:0]         done_o;
   logic [DW-1:0]           rd_data;

   assign op        = stage_op_e'(cmd_op);
   assign fill_pend = fill_act_q && !done_o[fill_reg_q];
   assign idx_nxt   = idx_q + LW'(1);
   assign is_last   = (idx_nxt == len_cur_q);

   always_comb begin
      cmd_ready = 1'b0;
      if (state_q == ST_IDLE) begin
         case (op)
            OP_ALLOC: cmd_ready = !all_busy;
            OP_FILL:  cmd_ready = !fill_pend;
            OP_MOUT:  cmd_ready = done_o[cmd_reg];
            default:  cmd_ready = 1'b1;
         endcase
      end
   end

   assign acc = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         idx_q         <= '0;
         len_cur_q     <= '0;
         cur_reg_q     <= '0;
         base_q        <= '0;
         free_after_q  <= 1'b0;
         fill_act_q    <= 1'b0;
         fill_reg_q    <= '0;
         alloc_valid_q <= 1'b0;
         alloc_idx_q   <= '0;
      end else begin
         alloc_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (acc) begin
               idx_q     <= '0;
               cur_reg_q <= cmd_reg;
               base_q    <= cmd_addr;
               case (op)
                  OP_ALLOC: begin
                     alloc_valid_q <= 1'b1;
                     alloc_idx_q   <= free_idx;
                  end
                  OP_FILL: begin
                     len_cur_q  <= cmd_len;
                     fill_act_q <= 1'b1;
                     fill_reg_q <= cmd_reg;
                     state_q    <= ST_FILL;
                  end
                  OP_MOUT: begin
                     len_cur_q <= len_o[cmd_reg];
                     state_q   <= ST_MOUT;
                  end
                  OP_MIN: begin
                     len_cur_q <= cmd_len;
                     state_q   <= ST_MIN;
                  end
                  OP_STORE, OP_STFREE: begin
                     len_cur_q    <= len_o[cmd_reg];
                     free_after_q <= (op == OP_STFREE);
                     if (len_o[cmd_reg] != '0) state_q <= ST_STORE;
                  end
                  default: ;
               endcase
            end
            ST_FILL, ST_STORE: if (mem_req_ready) begin
               idx_q <= idx_nxt;
               if (is_last) state_q <= ST_IDLE;
            end
            ST_MOUT: if (mo_ready) begin
               idx_q <= idx_nxt;
               if (is_last) state_q <= ST_IDLE;
            end
            ST_MIN: if (mi_valid) begin
               idx_q <= idx_nxt;
               if (is_last) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign clr_en  = (acc && op == OP_FREE)
                 || (acc && op == OP_STFREE && len_o[cmd_reg] == '0)
                 || (state_q == ST_STORE && mem_req_ready && is_last && free_after_q);
   assign clr_idx = (state_q == ST_IDLE) ? cmd_reg : cur_reg_q;

   vstage_alloc #(.NREG(NREG)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (acc && op == OP_ALLOC),
      .set_idx  (free_idx),
      .clr_en   (clr_en),
      .clr_idx  (clr_idx),
      .free_idx (free_idx),
      .all_busy (all_busy)
   );

   vstage_track #(.NREG(NREG), .DEPTH(DEPTH)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (acc && (op == OP_FILL || op == OP_MIN)),
      .set_reg   (cmd_reg),
      .set_len   (cmd_len),
      .inc_a_en  (mem_rsp_valid && fill_pend),
      .inc_a_reg (fill_reg_q),
      .inc_b_en  (state_q == ST_MIN && mi_valid),
      .inc_b_reg (cur_reg_q),
      .len_o     (len_o),
      .cnt_o     (cnt_o),
      .done_o    (done_o)
   );

   vstage_regfile #(.NREG(NREG), .DEPTH(DEPTH), .DW(DW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (mem_rsp_valid && fill_pend),
      .wa_reg  (fill_reg_q),
      .wa_idx  (cnt_o[fill_reg_q]),
      .wa_data (mem_rsp_data),
      .wb_en   (state_q == ST_MIN && mi_valid),
      .wb_reg  (cur_reg_q),
      .wb_idx  (idx_q),
      .wb_data (mi_data),
      .rd_reg  (cur_reg_q),
      .rd_idx  (idx_q),
      .rd_data (rd_data)
   );

   assign alloc_valid   = alloc_valid_q;
   assign alloc_idx     = alloc_idx_q;
   assign mem_req_valid = (state_q == ST_FILL) || (state_q == ST_STORE);
   assign mem_req_we    = (state_q == ST_STORE);
   assign mem_req_addr  = base_q + AW'(idx_q);
   assign mem_req_wdata = rd_data;
   assign mo_valid      = (state_q == ST_MOUT);
   assign mo_data       = rd_data;
   assign mo_last       = mo_valid && is_last;
   assign mi_ready      = (state_q == ST_MIN);

   // R4
   mout_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mo_valid |-> done_o[cur_reg_q]);

   // R5
   mout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mo_valid && !mo_ready |=> mo_valid && $stable(mo_data) && $stable(mo_last));

   // R10
   mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_we) && $stable(mem_req_wdata));

   // R11
   rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> fill_pend);

   // R3
   fill_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (op == OP_FILL || op == OP_MIN) |-> cmd_len != '0 && cmd_len <= LW'(DEPTH));

endmodule

// File: tb/vstage_top_bench.sv
module vstage_top_bench;
   import vstage_pkg::*;

   localparam int RW = 3;
   localparam int LW = 4;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = '0;
   logic [RW-1:0] cmd_reg = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [LW-1:0] cmd_len = '0;
   logic          alloc_valid;
   logic [RW-1:0] alloc_idx;
   logic          mem_req_valid, mem_req_we;
   logic          mem_req_ready = 1'b0;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_data = '0;
   logic          mo_valid, mo_last;
   logic          mo_ready = 1'b0;
   logic [DW-1:0] mo_data;
   logic          mi_valid = 1'b0;
   logic          mi_ready;
   logic [DW-1:0] mi_data = '0;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   vstage_top u_vstage_top (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mo_valid(mo_valid), .mo_ready(mo_ready), .mo_data(mo_data), .mo_last(mo_last),
      .mi_valid(mi_valid), .mi_ready(mi_ready), .mi_data(mi_data)
   );

   // ---------------- memory model: in-order reads, varying latency ----------
   function automatic logic [31:0] init_word(input int a);
      return 32'hC0DE0000 ^ (32'(a) * 32'h9E37);
   endfunction

   function automatic logic [31:0] mi_word(input int s, input int i);
      return 32'h5A000000 + 32'(s * 16 + i);
   endfunction

   logic [255:0]  wr_flag;
   logic [31:0]   wr_data [256];
   int            cyc = 0;
   int            last_due = 0;
   int            due;
   int            rsp_due [$];
   logic [31:0]   rsp_dat [$];

   function automatic logic [31:0] model_rd(input int a);
      return wr_flag[a] ? wr_data[a] : init_word(a);
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         wr_flag       <= '0;
         mem_req_ready <= 1'b0;
         mem_rsp_valid <= 1'b0;
      end else begin
         mem_req_ready <= (cyc % 3) != 1;
         if (rsp_due.size() > 0 && rsp_due[0] <= cyc) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rsp_dat.pop_front();
            void'(rsp_due.pop_front());
         end else begin
            mem_rsp_valid <= 1'b0;
         end
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
               wr_flag[mem_req_addr[7:0]] <= 1'b1;
               wr_data[mem_req_addr[7:0]] <= mem_req_wdata;
            end else begin
               due = cyc + 2 + (cyc % 4);
               if (due <= last_due) due = last_due + 1;
               last_due = due;
               rsp_due.push_back(due);
               rsp_dat.push_back(model_rd(int'(mem_req_addr[7:0])));
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input stage_op_e op, input int r, input int a, input int l,
                       output int stalls);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_reg   = RW'(r);
      cmd_addr  = AW'(a);
      cmd_len   = LW'(l);
      stalls    = 0;
      #1;
      while (!cmd_ready) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_alloc(input int exp_idx, input string req);
      int st;
      send(OP_ALLOC, 0, 0, 0, st);
      chk(alloc_valid && alloc_idx == RW'(exp_idx), req, 32'(alloc_idx), 32'(exp_idx));
   endtask

   // kind 0: initial memory words from base; kind 1: move-in pattern seed base
   task automatic collect(input int n, input int kind, input int base,
                          input bit throttle, input string req);
      int got = 0;
      int k = 0;
      int bad = 0;
      logic [31:0] exp;
      while (got < n && k < 200) begin
         mo_ready = throttle ? (k % 2 == 1) : 1'b1;
         #1;
         if (mo_valid && mo_ready) begin
            exp = (kind == 0) ? init_word(base + got) : mi_word(base, got);
            if (mo_data !== exp || mo_last !== (got == n - 1)) begin
               bad++;
               $display("FAIL %s elem %0d actual=%h last=%b expected=%h last=%b",
                        req, got, mo_data, mo_last, exp, got == n - 1);
            end
            got++;
         end
         k++;
         @(negedge clk);
      end
      mo_ready = 1'b0;
      tests++;
      if (bad != 0 || got != n) begin
         fails++;
         $display("FAIL %s move-out count actual=%0d expected=%0d", req, got, n);
      end
   endtask

   task automatic push_in(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         if (i % 2 == 1) begin
            mi_valid = 1'b0;
            @(negedge clk);
         end
         mi_valid = 1'b1;
         mi_data  = mi_word(seed, i);
         #1;
         while (!mi_ready) begin
            @(negedge clk);
            #1;
         end
         @(negedge clk);
      end
      mi_valid = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      @(negedge clk);
      chk(cmd_ready === 1'b1, "R12 cmd_ready", 32'(cmd_ready), 1);
      chk(mem_req_valid === 1'b0 && mo_valid === 1'b0 && alloc_valid === 1'b0,
          "R12 outputs idle", {29'd0, mem_req_valid, mo_valid, alloc_valid}, 0);
   endtask

   task automatic t_alloc_all;
      for (int i = 0; i < 8; i++) do_alloc(i, "R1 lowest free");
      @(negedge clk);
      chk(alloc_valid === 1'b0, "R1 single-cycle strobe", 32'(alloc_valid), 0);
   endtask

   task automatic t_full_stall;
      int low = 0;
      int st;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = OP_ALLOC;
      for (int i = 0; i < 6; i++) begin
         #1;
         if (!cmd_ready) low++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(low == 6, "R2 stall while full", 32'(low), 6);
      send(OP_FREE, 3, 0, 0, st);
      do_alloc(3, "R9 freed register reused");
   endtask

   task automatic t_fill_move;
      int st;
      send(OP_FILL, 0, 10, 5, st);
      send(OP_MOUT, 0, 0, 0, st);
      chk(st > 0, "R4 move-out waits for fill", 32'(st), 1);
      collect(5, 0, 10, 1'b0, "R3 R5 fill data");
   endtask

   task automatic t_back_to_back_fill;
      int st;
      send(OP_FILL, 4, 100, 8, st);
      send(OP_FILL, 5, 200, 3, st);
      chk(st > 0, "R11 second fill held", 32'(st), 1);
      send(OP_MOUT, 4, 0, 0, st);
      collect(8, 0, 100, 1'b1, "R5 throttled move-out r4");
      send(OP_MOUT, 5, 0, 0, st);
      collect(3, 0, 200, 1'b1, "R3 move-out r5");
   endtask

   task automatic t_store_keep;
      int st;
      send(OP_MIN, 1, 0, 4, st);
      push_in(4, 1);
      send(OP_STORE, 1, 40, 0, st);
      repeat (20) @(negedge clk);
      for (int i = 0; i < 4; i++)
         chk(model_rd(40 + i) === mi_word(1, i), "R7 store data",
             model_rd(40 + i), mi_word(1, i));
      send(OP_MOUT, 1, 0, 0, st);
      collect(4, 1, 1, 1'b0, "R6 move-in contents");
      send(OP_FREE, 3, 0, 0, st);
      do_alloc(3, "R7 stored register still allocated");
   endtask

   task automatic t_store_free;
      int st;
      send(OP_MIN, 2, 0, 3, st);
      push_in(3, 2);
      send(OP_STFREE, 2, 60, 0, st);
      repeat (20) @(negedge clk);
      for (int i = 0; i < 3; i++)
         chk(model_rd(60 + i) === mi_word(2, i), "R8 store data",
             model_rd(60 + i), mi_word(2, i));
      chk(model_rd(63) === init_word(63), "R7 no write past length",
          model_rd(63), init_word(63));
      do_alloc(2, "R8 store-and-free released register");
   endtask

   // ---------------- main and watchdog ----------------
   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alloc_all();
      t_full_stall();
      t_fill_move();
      t_back_to_back_fill();
      t_store_keep();
      t_store_free();
      repeat (5) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule